// File: doc/BRIEF.md
# Dual-Path Input Integrity Monitor

This block stands in front of a 128-bit block-cipher core and protects the two values the core consumes: the data block and the key. Each value reaches the block twice. The main copy travels through logic that may have been altered. The parallel copy is a protected tap taken straight from the entered input. For each value, a comparator checks the main copy against the parallel copy. The result drives that value's own selector. When the copies agree, the main copy goes on to the cipher. When they differ, the selector cuts the main copy off and forwards the parallel copy instead. The cipher therefore always receives the value that was entered.

An input is accepted on a one-cycle valid pulse. One clock later the block presents the selected data, the selected key and a 2-bit tamper code, together with an output valid strobe. Bit 0 of the code flags a corrupted data path and bit 1 flags a corrupted key path. The outputs hold until the next accepted input. A sticky alarm records that some tamper code was ever nonzero, and a clear input drops it.

Top module: `input_integrity_guard`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and after it drops until the first accepted input, `out_vld`, `status`, `alarm`, `out_data` and `out_key` are all zero.
- R2: When `main_data` equals `par_data` at an accepted input, `out_data` equals that value in the cycle after acceptance.
- R3: When `main_data` differs from `par_data` in any bit at an accepted input, `out_data` equals `par_data` in the cycle after acceptance. So `out_data` always matches the parallel copy.
- R4: The key is judged on its own: `out_key` equals `par_key` in the cycle after acceptance, whatever the data paths do. `main_key` is forwarded when the two key copies agree.
- R5: The code in `status` has bit 0 set when the data copies differ and bit 1 set when the key copies differ. This gives 00 for clean, 01 for data only, 10 for key only and 11 for both. It appears in the cycle after acceptance.
- R6: `out_vld` is high exactly in the cycle after a cycle with `in_vld` high, and low otherwise.
- R7: In cycles without `in_vld`, changes on the main or parallel inputs have no effect: `out_data`, `out_key` and `status` keep the values of the last accepted input.
- R8: `alarm` goes high in the same cycle that a nonzero `status` is presented. It stays high through later clean inputs.
- R9: A cycle with `alarm_clr` high drops `alarm` in the next cycle. If that same cycle accepts an input with a nonzero code, the alarm stays set.
- R10: A single-bit difference at any position, including bit 0, bit 127 and the bits on either side of each 32-bit boundary, is detected on both the data and the key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Accept strobe for the four input copies |
| main_data | input | 128 | Data block over the main path |
| par_data | input | 128 | Data block over the protected parallel path |
| main_key | input | 128 | Key over the main path |
| par_key | input | 128 | Key over the protected parallel path |
| alarm_clr | input | 1 | Clears the sticky alarm |
| out_vld | output | 1 | Strobe, high one cycle after acceptance |
| out_data | output | 128 | Selected data block toward the cipher |
| out_key | output | 128 | Selected key toward the cipher |
| status | output | 2 | Tamper code: bit 0 data, bit 1 key |
| alarm | output | 1 | Sticky flag for any nonzero tamper code |

## Verification
The bench flips single bits at the edges of the word and around every segment boundary. A comparator that dropped a segment or tested only part of the width would then forward a corrupted main copy and report a clean code. It mixes data-only and key-only corruption, so that swapped status bits or a shared selector would show up as the wrong field being replaced. During idle cycles it keeps changing the inputs: a design that loaded without `in_vld` would drift. It also raises the alarm clear in the same cycle as a tampered input, to catch a clear that wrongly beats a new event.

// File: rtl/igd_pkg.sv
package igd_pkg;

   localparam int CODE_W = 2;

   typedef enum logic [CODE_W-1:0] {
      TAMPER_NONE = 2'b00,
      TAMPER_DATA = 2'b01,
      TAMPER_KEY  = 2'b10,
      TAMPER_BOTH = 2'b11
   } tamper_e;

   function automatic tamper_e tamper_code(input logic data_bad, input logic key_bad);
      tamper_e c;
      case ({key_bad, data_bad})
         2'b00:   c = TAMPER_NONE;
         2'b01:   c = TAMPER_DATA;
         2'b10:   c = TAMPER_KEY;
         default: c = TAMPER_BOTH;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/field_compare.sv
module field_compare #(
   parameter int W     = 128,
   parameter int SEG_W = 32,
   parameter bit TREE  = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] main_v,
   input  logic [W-1:0] par_v,
   output logic         differ
);

   localparam int NSEG = W / SEG_W;

   generate
      if (W < 1 || SEG_W < 1 || (W % SEG_W) != 0) begin : g_bad_cfg
         $error("field_compare: W must be a positive multiple of SEG_W");
      end

      if (TREE) begin : g_tree
         logic [NSEG-1:0] seg_diff;
         for (genvar s = 0; s < NSEG; s++) begin : g_seg
            assign seg_diff[s] = |(main_v[s*SEG_W +: SEG_W] ^ par_v[s*SEG_W +: SEG_W]);
         end
         assign differ = |seg_diff;
      end else begin : g_flat
         assign differ = (main_v != par_v);
      end
   endgenerate

   // R10
   cmp_detect_chk: assert property (@(posedge clk) disable iff (rst)
      differ == (main_v !== par_v));

endmodule

// File: rtl/field_steer.sv
module field_steer #(
   parameter int W = 128
) (
   input  logic [W-1:0] main_v,
   input  logic [W-1:0] par_v,
   input  logic         use_par,
   output logic [W-1:0] sel_v
);

   generate
      if (W < 1) begin : g_bad_cfg
         $error("field_steer: W must be positive");
      end
   endgenerate

   always_comb begin
      sel_v = use_par ? par_v : main_v;
   end

endmodule

// File: rtl/tamper_report.sv
module tamper_report
   import igd_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              accept,
   input  logic              data_bad,
   input  logic              key_bad,
   input  logic              alarm_clr,
   output logic [CODE_W-1:0] status,
   output logic              alarm
);

   tamper_e code_q;
   logic    event_now;

   assign event_now = accept && (data_bad || key_bad);

   always_ff @(posedge clk) begin
      if (rst) begin
         code_q <= TAMPER_NONE;
         alarm  <= 1'b0;
      end else begin
         if (accept) begin
            code_q <= tamper_code(data_bad, key_bad);
         end
         if (event_now) begin
            alarm <= 1'b1;
         end else if (alarm_clr) begin
            alarm <= 1'b0;
         end
      end
   end

   assign status = code_q;

   // R5
   code_bits_chk: assert property (@(posedge clk) disable iff (rst)
      accept |=> (status[0] == $past(data_bad)) && (status[1] == $past(key_bad)));

   // R8
   alarm_set_chk: assert property (@(posedge clk) disable iff (rst)
      event_now |=> alarm && (status != 2'b00));

   // R9
   alarm_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (alarm_clr && !event_now) |=> !alarm);

endmodule

// File: rtl/input_integrity_guard.sv
module input_integrity_guard
   import igd_pkg::*;
#(
   parameter int DATA_W  = 128,
   parameter int KEY_W   = 128,
   parameter int SEG_W   = 32,
   parameter bit CMP_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] main_data,
   input  logic [DATA_W-1:0] par_data,
   input  logic [KEY_W-1:0]  main_key,
   input  logic [KEY_W-1:0]  par_key,
   input  logic              alarm_clr,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data,
   output logic [KEY_W-1:0]  out_key,
   output logic [CODE_W-1:0] status,
   output logic              alarm
);

   logic              data_bad, key_bad;
   logic [DATA_W-1:0] data_sel;
   logic [KEY_W-1:0]  key_sel;

   field_compare #(.W(DATA_W), .SEG_W(SEG_W), .TREE(CMP_TREE)) u_cmp_data (
      .clk(clk), .rst(rst), .main_v(main_data), .par_v(par_data), .differ(data_bad));

   field_compare #(.W(KEY_W), .SEG_W(SEG_W), .TREE(CMP_TREE)) u_cmp_key (
      .clk(clk), .rst(rst), .main_v(main_key), .par_v(par_key), .differ(key_bad));

   field_steer #(.W(DATA_W)) u_steer_data (
      .main_v(main_data), .par_v(par_data), .use_par(data_bad), .sel_v(data_sel));

   field_steer #(.W(KEY_W)) u_steer_key (
      .main_v(main_key), .par_v(par_key), .use_par(key_bad), .sel_v(key_sel));

   tamper_report u_report (
      .clk(clk), .rst(rst), .accept(in_vld), .data_bad(data_bad), .key_bad(key_bad),
      .alarm_clr(alarm_clr), .status(status), .alarm(alarm));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_data <= '0;
         out_key  <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_data <= data_sel;
            out_key  <= key_sel;
         end
      end
   end

   // R6
   vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);

   // R6
   vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);

   // R3
   data_par_chk: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_data == $past(par_data));

   // R4
   key_par_chk: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_key == $past(par_key));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(out_data) && $stable(out_key) && $stable(status));

endmodule

// File: tb/input_integrity_guard_tb.sv
module input_integrity_guard_tb;

   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_vld = 1'b0;
   logic [127:0] main_data = '0, par_data = '0, main_key = '0, par_key = '0;
   logic         alarm_clr = 1'b0;
   logic         out_vld;
   logic [127:0] out_data, out_key;
   logic [1:0]   status;
   logic         alarm;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // reference state
   logic         m_vld = 1'b0;
   logic [127:0] m_data = '0, m_key = '0;
   logic [1:0]   m_st = 2'b00;
   logic         m_alarm = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   input_integrity_guard u_dut (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .main_data(main_data), .par_data(par_data),
      .main_key(main_key), .par_key(par_key),
      .alarm_clr(alarm_clr),
      .out_vld(out_vld), .out_data(out_data), .out_key(out_key),
      .status(status), .alarm(alarm));

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // reference update for one edge, from the values this process drove
   task automatic model_edge();
      if (rst) begin
         m_vld = 0; m_data = '0; m_key = '0; m_st = 2'b00; m_alarm = 0;
      end else begin
         m_vld = in_vld;
         if (in_vld) begin
            m_data = (main_data == par_data) ? main_data : par_data;
            m_key  = (main_key == par_key) ? main_key : par_key;
            m_st   = {main_key != par_key, main_data != par_data};
            if (m_st != 2'b00) m_alarm = 1;
            else if (alarm_clr) m_alarm = 0;
         end else if (alarm_clr) begin
            m_alarm = 0;
         end
      end
   endtask

   task automatic compare_all(input string grp);
      chk({grp, " R6 out_vld"}, {127'd0, out_vld}, {127'd0, m_vld});
      chk({grp, " R2/R3 out_data"}, out_data, m_data);
      chk({grp, " R4 out_key"}, out_key, m_key);
      chk({grp, " R5 status"}, {126'd0, status}, {126'd0, m_st});
      chk({grp, " R8/R9 alarm"}, {127'd0, alarm}, {127'd0, m_alarm});
   endtask

   // one clock: drive after the falling edge, compare after the next falling edge
   task automatic cycle(input string grp, input logic v,
                        input logic [127:0] md, input logic [127:0] pd,
                        input logic [127:0] mk, input logic [127:0] pk,
                        input logic clr);
      in_vld = v; main_data = md; par_data = pd; main_key = mk; par_key = pk; alarm_clr = clr;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all(grp);
      if (out_vld) begin
         // R3: the output always equals the parallel copy of the accepted input
         chk({grp, " R3 out_data==par"}, out_data, pd);
      end
   endtask

   task automatic send(input string grp, input logic [127:0] d, input logic [127:0] dflip,
                       input logic [127:0] k, input logic [127:0] kflip, input logic clr);
      cycle(grp, 1'b1, d ^ dflip, d, k ^ kflip, k, clr);
   endtask

   initial begin
      @(negedge clk);
      repeat (3) begin
         @(posedge clk); model_edge(); @(negedge clk);
         compare_all("R1 in reset");
      end
      rst = 1'b0;
      cycle("R1 after reset", 1'b0, rnd128(), rnd128(), rnd128(), rnd128(), 1'b0);

      // R2: clean inputs
      for (int i = 0; i < 20; i++) begin
         logic [127:0] d = rnd128(), k = rnd128();
         send("R2 clean", d, '0, k, '0, 1'b0);
      end

      // R10: single-bit flips at word edges and segment seams, data then key
      for (int i = 0; i < 10; i++) begin
         int pos;
         case (i)
            0: pos = 0;   1: pos = 127; 2: pos = 31; 3: pos = 32; 4: pos = 63;
            5: pos = 64;  6: pos = 95;  7: pos = 96; 8: pos = 1;  default: pos = 126;
         endcase
         begin
            logic [127:0] d = rnd128(), k = rnd128();
            send("R10 data flip", d, 128'd1 << pos, k, '0, 1'b0);
            send("R10 key flip",  d, '0, k, 128'd1 << pos, 1'b0);
         end
      end

      // R8: alarm stays through clean inputs; R9: clear alone
      for (int i = 0; i < 4; i++) begin
         logic [127:0] d = rnd128(), k = rnd128();
         send("R8 sticky", d, '0, k, '0, 1'b0);
      end
      cycle("R9 clear", 1'b0, rnd128(), rnd128(), rnd128(), rnd128(), 1'b1);
      cycle("R9 after clear", 1'b0, '0, '0, '0, '0, 1'b0);

      // R4/R5: mixed patterns
      for (int i = 0; i < 60; i++) begin
         logic [127:0] d = rnd128(), k = rnd128();
         logic [127:0] df = (i % 4 == 1 || i % 4 == 3) ? rnd128() | 128'd1 : '0;
         logic [127:0] kf = (i % 4 >= 2) ? rnd128() | (128'd1 << 127) : '0;
         send("R5 mixed", d, df, k, kf, (i % 7 == 0));
         if (i % 5 == 0)
            cycle("R7 idle noise", 1'b0, rnd128(), rnd128(), rnd128(), rnd128(), 1'b0);
      end

      // R9: clear coincides with a tampered input -> alarm stays set
      cycle("R9 clear", 1'b0, '0, '0, '0, '0, 1'b1);
      send("R9 clr+tamper", rnd128(), 128'h10, rnd128(), '0, 1'b1);
      // R9: clear with clean input drops it
      send("R9 clr+clean", rnd128(), '0, rnd128(), '0, 1'b1);

      // R7: long idle stretch with moving inputs
      send("R7 load", rnd128(), '0, rnd128(), 128'h4, 1'b0);
      for (int i = 0; i < 15; i++)
         cycle("R7 idle", 1'b0, rnd128(), rnd128(), rnd128(), rnd128(), 1'b0);

      // back-to-back accepts
      for (int i = 0; i < 20; i++) begin
         logic [127:0] d = rnd128(), k = rnd128();
         send("R6 burst", d, (i % 3 == 0) ? rnd128() : '0, k, (i % 2 == 0) ? rnd128() : '0, 1'b0);
      end
      cycle("R6 tail", 1'b0, '0, '0, '0, '0, 1'b0);

      // R1: reset mid-stream clears everything
      rst = 1'b1;
      cycle("R1 re-reset", 1'b1, rnd128(), rnd128(), rnd128(), rnd128(), 1'b0);
      rst = 1'b0;
      cycle("R1 post", 1'b0, '0, '0, '0, '0, 1'b0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule